// File: doc/BRIEF.md
# Multicart Outer-Bank Sequencer

This block sits in front of a bank-select mapper on a multi-game cartridge. The inner mapper supplies an 8 KB program bank number and a 1 KB character bank number. The block combines them with four outer registers and produces the bank numbers that reach the memories. The outer program register picks a slice of the program space, and a program mask register limits how much of that slice the inner mapper can reach. For character banks, a control register sets a power-of-two window for the inner bank and supplies the top bank bit. A fourth register supplies the base that is ORed into the character bank.

Software loads all four registers through one write window in the CPU range 0x6000-0x7FFF, so only CPU address bits 15..13 enter the block. A hidden two-bit pointer picks the register for each write and steps forward after every accepted write. Once a game has been chosen, the loader sets the lock bit, and from then on the window is dead until reset. Both outputs are pure combinational functions of the inner bank inputs and the stored registers.

Top module: `outer_bank_seq`

## Requirements
- R1: After reset all four outer registers and the write pointer are zero, so `prg_bank` = `inner_prg` & 0x3F and `chr_bank` = 0.
- R2: A write whose address bits 15..13 are not 3'b011 changes no register and does not move the pointer.
- R3: Accepted writes fill the registers in the order base-character (0), program-base (1), character-control (2), program-mask (3). After the fourth write the pointer wraps back to register 0.
- R4: While bit 6 of register 3 is 1, writes change no register and do not move the pointer.
- R5: `prg_bank` = (`inner_prg` & {2'b00, ~reg3[5:0]}) | reg1.
- R6: When reg2 bit 3 is 1, the inner character bank is masked to its low reg2[2:0]+1 bits before it is ORed with reg0.
- R7: When reg2 bit 3 is 0, the inner character bank has no effect, and `chr_bank[7:0]` = reg0.
- R8: `chr_bank[8]` equals reg2 bit 4.
- R9: A register write is visible on the outputs right after the clock edge that takes it. A change of the inner bank inputs is visible without any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr | input | 1 | CPU write strobe, sampled on the rising edge |
| cpu_addr_top | input | 3 | CPU address bits 15..13 |
| cpu_data | input | 8 | CPU write data |
| inner_prg | input | 8 | Program bank number from the inner mapper |
| inner_chr | input | 8 | Character bank number from the inner mapper |
| prg_bank | output | 8 | Final 8 KB program bank |
| chr_bank | output | 9 | Final 1 KB character bank |

## Verification
The hardest state to reach from the ports is the write pointer part-way through a cycle at the moment the lock lands, or after writes outside the window. The pointer cannot be seen directly, so the bench infers it from which register the next write changes. Directed sequences mix out-of-window writes, wrap the pointer, and lock with the pointer at each position. A random phase keeps the lock bit rare in the data so that long write runs happen before a lock, and it resets from time to time to start new sequences.

// File: rtl/outer_bank_seq.sv
module outer_bank_seq #(
  parameter int PW = 8,
  parameter int CW = 8,
  parameter logic [2:0] WIN = 3'b011
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_wr,
  input  logic [2:0]    cpu_addr_top,
  input  logic [7:0]    cpu_data,
  input  logic [PW-1:0] inner_prg,
  input  logic [CW-1:0] inner_chr,
  output logic [PW-1:0] prg_bank,
  output logic [CW:0]   chr_bank
);

  logic [3:0][7:0] ob;
  logic [1:0]      idx;
  logic            locked, hit, take;
  logic [CW-1:0]   cmask;
  logic [CW:0]     cfull;
  logic            unused_bits;

  assign locked = ob[3][6];
  assign hit    = cpu_addr_top == WIN;
  assign take   = cpu_wr && hit && !locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ob  <= '0;
      idx <= 2'd0;
    end else if (take) begin
      ob[idx] <= cpu_data;
      idx     <= idx + 2'd1;
    end
  end

  assign prg_bank = (inner_prg & PW'({2'b00, ~ob[3][5:0]})) | PW'(ob[1]);

  assign cfull = (CW+1)'((CW+1)'(1) << ({1'b0, ob[2][2:0]} + 4'd1)) - (CW+1)'(1);
  assign cmask = ob[2][3] ? cfull[CW-1:0] : '0;
  assign chr_bank = {ob[2][4], (inner_chr & cmask) | CW'(ob[0])};

  assign unused_bits = ^{ob[2][7:5], ob[3][7], cfull[CW]};

  assert_ptr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> idx == $past(idx) + 2'd1);

  assert_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && !hit) |=> ($stable(ob) && $stable(idx)));

  assert_lock_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> ($stable(ob) && $stable(idx) && locked));

  assert_prg_base_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (prg_bank & PW'(ob[1])) == PW'(ob[1]));

  assert_chr_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ob[2][3] |-> chr_bank[CW-1:0] == CW'(ob[0]));

  assert_chr_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ob[2][3] |-> ((chr_bank[CW-1:0] & ~CW'(ob[0])) & ~cmask) == '0);

endmodule

// File: tb/outer_bank_seq_test.sv
module outer_bank_seq_test;
  logic       clk = 0, rst_n = 0, cpu_wr = 0;
  logic [2:0] cpu_addr_top = 0;
  logic [7:0] cpu_data = 0, inner_prg = 0, inner_chr = 0;
  logic [7:0] prg_bank;
  logic [8:0] chr_bank;

  int checks = 0, fails = 0;
  logic [7:0] m [4];
  logic [1:0] mi;

  always #10 clk = ~clk;

  outer_bank_seq uut (.clk, .rst_n, .cpu_wr, .cpu_addr_top, .cpu_data,
                      .inner_prg, .inner_chr, .prg_bank, .chr_bank);

  function automatic logic [7:0] exp_prg(logic [7:0] ip);
    return (ip & {2'b00, ~m[3][5:0]}) | m[1];
  endfunction

  function automatic logic [8:0] exp_chr(logic [7:0] ic);
    logic [8:0] msk;
    msk = m[2][3] ? ((9'd1 << (m[2][2:0] + 1)) - 9'd1) : 9'd0;
    return {m[2][4], (ic & msk[7:0]) | m[0]};
  endfunction

  task automatic cmp(string tag, logic [8:0] act, logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic probe(string tag, logic [7:0] ip, logic [7:0] ic);
    inner_prg = ip; inner_chr = ic;
    #1;
    cmp(tag, {1'b0, prg_bank}, {1'b0, exp_prg(ip)});
    cmp(tag, chr_bank, exp_chr(ic));
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    for (int i = 0; i < 4; i++) m[i] = 0;
    mi = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    cpu_wr = 1; cpu_addr_top = a; cpu_data = d;
    @(negedge clk);
    cpu_wr = 0;
    if (a == 3'b011 && !m[3][6]) begin m[mi] = d; mi = mi + 2'd1; end
  endtask

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    do_reset();
    inner_prg = 8'hFF; inner_chr = 8'hFF; #1;
    cmp("R1 prg", {1'b0, prg_bank}, 9'h03F);
    cmp("R1 chr", chr_bank, 9'h000);

    wr(3'b010, 8'hFF); wr(3'b100, 8'hFF);
    wr(3'b011, 8'h12);
    probe("R2 pointer held", 8'hFF, 8'hFF);
    inner_chr = 8'hFF; #1;
    cmp("R2 reg0 got first in-window write", chr_bank, 9'h012);

    do_reset();
    wr(3'b011, 8'h05); wr(3'b011, 8'h40); wr(3'b011, 8'h1A); wr(3'b011, 8'h0F);
    inner_prg = 8'hFF; inner_chr = 8'hFF; #1;
    cmp("R3 R5 prg", {1'b0, prg_bank}, 9'h070);
    cmp("R3 R6 R8 chr", chr_bank, 9'h107);
    inner_chr = 8'h00; #1;
    cmp("R9 inner change no clock", chr_bank, 9'h105);
    wr(3'b011, 8'h80);
    inner_chr = 8'hFF; #1;
    cmp("R3 wrap to reg0 R9", chr_bank, 9'h187);

    do_reset();
    wr(3'b011, 8'h33); wr(3'b011, 8'h00); wr(3'b011, 8'h10);
    probe("R7 chr disabled", 8'hAA, 8'hFF);
    inner_chr = 8'hCC; #1;
    cmp("R7 R8 inner ignored", chr_bank, 9'h133);

    for (int p = 0; p < 4; p++) begin
      do_reset();
      for (int k = 0; k < p; k++) wr(3'b011, 8'h00);
      wr(3'b011, 8'h00); wr(3'b011, 8'h01); wr(3'b011, 8'h0C); wr(3'b011, 8'h41);
      for (int k = 0; k < 4; k++) wr(3'b011, 8'hFF);
      probe("R4 lock holds", 8'hFF, 8'hFF);
    end

    do_reset();
    for (int n = 0; n < 3000; n++) begin
      logic [7:0] d;
      logic [2:0] a;
      if ($urandom % 100 == 0) do_reset();
      d = 8'($urandom);
      if ($urandom % 16 != 0) d[6] = 1'b0;
      a = ($urandom % 4 == 0) ? 3'($urandom) : 3'b011;
      wr(a, d);
      probe("R5 R6 R7 R8 random", 8'($urandom), 8'($urandom));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule